// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock with Dead Time

This block conditions the two logic commands of a half-bridge driver, one for the upper switch and one for the lower, before they reach the gate stages. It registers both commands, never lets the two gate commands be on in the same cycle, and drops both sides when the controller asks for both at once. Every turn-on waits out a fixed internal dead time, counted in clock cycles. The wait applies even when the controller switches from one side to the other with no gap of its own, and both sides use the same count.

A fault manager steers the block through two control inputs. One forces both gates off and discards any turn-on wait in progress. The other freezes both gate commands and both wait counters where they stand, so that another phase can finish a protective sequence without this phase changing state. Any command pulse too short to outlast the dead time is absorbed and produces no gate pulse.

Top module: `hb_interlock`

## Requirements
- R1: While `rst_n` is low, both gate outputs are 0 and both dead-time counters are cleared.
- R2: A command pair with both sides high, once registered, turns both gates off at the next clock edge (outside hold).
- R3: A command that goes high at input-sample edge E0 and stays high raises its gate at edge E0+DT_CYCLES+1, when nothing is forcing or holding.
- R4: A command that goes low at sample edge E0 drops its gate at edge E0+1 (outside hold).
- R5: When the commands switch directly from one side to the other with no external gap, the newly enabled gate rises exactly DT_CYCLES clock cycles after the other gate falls.
- R6: The upper and lower sides use identical turn-on and turn-off timing.
- R7: A command that is high for DT_CYCLES sample edges or fewer produces no gate pulse.
- R8: With `force_off` high at an edge, both gates are 0 and both counters are 0 after that edge. After release, a full dead time is needed again before any turn-on.
- R9: With `hold` high and `force_off` low at an edge, both gates and both counters keep their values through that edge. Counting resumes from the frozen value once hold ends.
- R10: The two gate outputs are never high at the same time.
- R11: `force_off` takes priority over `hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | Upper-side on command from the controller |
| lo_cmd | input | 1 | Lower-side on command from the controller |
| force_off | input | 1 | Force both gates off and clear pending waits (active high) |
| hold | input | 1 | Freeze gates and wait counters (active high) |
| hi_gate | output | 1 | Upper-side gate command |
| lo_gate | output | 1 | Lower-side gate command |

## Verification
The assertions assume that all four inputs are synchronous to `clk` and are already free of glitches. They also assume that `force_off` and `hold` act at clock edges, so each edge sees a single well-defined request. The stimulus respects these assumptions by changing every input only on the falling clock edge, one cycle at a time. It covers both-high commands, direct side swaps, short pulses, and hold or force raised in the middle of a count and while a gate is on.

// File: rtl/hb_ilk_pkg.sv
package hb_ilk_pkg;

  localparam int CNT_BITS = 16;
  typedef logic [CNT_BITS-1:0] dt_count_t;

  typedef enum logic [1:0] {
    ACT_RUN  = 2'd0,
    ACT_HOLD = 2'd1,
    ACT_KILL = 2'd2
  } act_t;

  // Kill wins over freeze; otherwise run normally.
  function automatic act_t pick_action(input logic kill, input logic freeze);
    if (kill)        return ACT_KILL;
    else if (freeze) return ACT_HOLD;
    else             return ACT_RUN;
  endfunction

  // bit0: upper request, bit1: lower request; both-high yields neither.
  function automatic logic [1:0] exclusive_req(input logic up, input logic dn);
    return {dn & ~up, up & ~dn};
  endfunction

  // Consecutive request cycles, saturating at the dead-time limit.
  function automatic dt_count_t count_next(input dt_count_t cur, input logic req,
                                           input dt_count_t lim);
    if (!req)        return '0;
    else if (cur >= lim) return lim;
    else             return cur + dt_count_t'(1);
  endfunction

  // A gate may be on only after the request survived the full limit.
  function automatic logic gate_next(input dt_count_t cur, input logic req,
                                     input dt_count_t lim);
    return req && (cur >= lim);
  endfunction

endpackage

// File: rtl/hb_ilk_sampler.sv
module hb_ilk_sampler
  import hb_ilk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd,
  output logic hi_req,
  output logic lo_req
);

  logic hi_s, lo_s;
  logic [1:0] pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_s <= 1'b0;
      lo_s <= 1'b0;
    end else begin
      hi_s <= hi_cmd;
      lo_s <= lo_cmd;
    end
  end

  assign pair   = exclusive_req(hi_s, lo_s);
  assign hi_req = pair[0];
  assign lo_req = pair[1];

endmodule

// File: rtl/hb_ilk_side.sv
module hb_ilk_side
  import hb_ilk_pkg::*;
#(
  parameter dt_count_t DT_LIMIT = dt_count_t'(16)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  act_t      action,
  output logic      gate,
  output dt_count_t count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate  <= 1'b0;
      count <= '0;
    end else begin
      case (action)
        ACT_KILL: begin
          gate  <= 1'b0;
          count <= '0;
        end
        ACT_HOLD: begin
          gate  <= gate;
          count <= count;
        end
        default: begin
          gate  <= gate_next(count, req, DT_LIMIT);
          count <= count_next(count, req, DT_LIMIT);
        end
      endcase
    end
  end

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_ilk_pkg::*;
#(
  parameter int DT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic force_off,
  input  logic hold,
  output logic hi_gate,
  output logic lo_gate
);

  localparam int        SIDES    = 2;
  localparam dt_count_t DT_LIMIT = dt_count_t'(DT_CYCLES);

  // Named internal events for the checker.
  logic      req_hi, req_lo;
  dt_count_t cnt_hi, cnt_lo;
  act_t      action;

  logic [SIDES-1:0] req_vec;
  logic [SIDES-1:0] gate_vec;
  dt_count_t        cnt_vec [SIDES];

  hb_ilk_sampler u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .hi_cmd (hi_cmd),
    .lo_cmd (lo_cmd),
    .hi_req (req_hi),
    .lo_req (req_lo)
  );

  assign action  = pick_action(force_off, hold);
  assign req_vec = {req_lo, req_hi};

  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      hb_ilk_side #(.DT_LIMIT(DT_LIMIT)) u_side (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_vec[s]),
        .action (action),
        .gate   (gate_vec[s]),
        .count  (cnt_vec[s])
      );
    end
  endgenerate

  assign hi_gate = gate_vec[0];
  assign lo_gate = gate_vec[1];
  assign cnt_hi  = cnt_vec[0];
  assign cnt_lo  = cnt_vec[1];

endmodule

// File: rtl/hb_ilk_checker.sv
module hb_ilk_checker
  import hb_ilk_pkg::*;
#(
  parameter int DT_CYCLES = 16
) (
  input logic      clk,
  input logic      rst_n,
  input logic      force_off,
  input logic      hold,
  input logic      hi_gate,
  input logic      lo_gate,
  input logic      req_hi,
  input logic      req_lo,
  input dt_count_t cnt_hi,
  input dt_count_t cnt_lo
);

  localparam dt_count_t LIM = dt_count_t'(DT_CYCLES);

  a_r10_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));

  a_r8_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!hi_gate && !lo_gate && cnt_hi == '0 && cnt_lo == '0));

  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !force_off) |=> ($stable(hi_gate) && $stable(lo_gate) &&
                              $stable(cnt_hi) && $stable(cnt_lo)));

  a_r3_hi_waits_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> ($past(cnt_hi) == LIM && $past(req_hi)));

  a_r6_lo_waits_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate) |-> ($past(cnt_lo) == LIM && $past(req_lo)));

  a_r4_hi_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_hi && !hold) |=> !hi_gate);

  a_r4_lo_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_lo && !hold) |=> !lo_gate);

  a_r2_no_req_both_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_hi && !req_lo && !hold) |=> (!hi_gate && !lo_gate));

endmodule

bind hb_interlock hb_ilk_checker #(.DT_CYCLES(DT_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .force_off (force_off),
  .hold      (hold),
  .hi_gate   (hi_gate),
  .lo_gate   (lo_gate),
  .req_hi    (req_hi),
  .req_lo    (req_lo),
  .cnt_hi    (cnt_hi),
  .cnt_lo    (cnt_lo)
);

// File: tb/hb_interlock_bench.sv
`timescale 1ns/1ps
module hb_interlock_bench;

  localparam int DT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd = 1'b0, lo_cmd = 1'b0, force_off = 1'b0, hold = 1'b0;
  logic hi_gate, lo_gate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hb_interlock #(.DT_CYCLES(DT)) u_hb_interlock (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .force_off(force_off), .hold(hold), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  // Scoreboard queues: expected {lo,hi} after each edge, with the requirement tag.
  logic [1:0] exp_q[$];
  string      tag_q[$];

  // Behavioural model: runs = edges the lone request has been seen, capped at DT.
  logic m_sh = 0, m_sl = 0, m_gh = 0, m_gl = 0;
  int   m_rh = 0, m_rl = 0;

  task automatic step(input logic h, input logic l, input logic fo, input logic hd,
                      input string tag);
    bit wh, wl;
    @(negedge clk);
    hi_cmd = h; lo_cmd = l; force_off = fo; hold = hd;
    if (fo) begin
      m_gh = 0; m_gl = 0; m_rh = 0; m_rl = 0;
    end else if (!hd) begin
      wh = m_sh && !m_sl;
      wl = m_sl && !m_sh;
      m_gh = wh && (m_rh >= DT);
      m_gl = wl && (m_rl >= DT);
      m_rh = wh ? ((m_rh < DT) ? m_rh + 1 : DT) : 0;
      m_rl = wl ? ((m_rl < DT) ? m_rl + 1 : DT) : 0;
    end
    m_sh = h; m_sl = l;
    exp_q.push_back({m_gl, m_gh});
    tag_q.push_back(tag);
  endtask

  task automatic run(input logic h, input logic l, input logic fo, input logic hd,
                     input int n, input string tag);
    for (int i = 0; i < n; i++) step(h, l, fo, hd, tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({lo_gate, hi_gate} == e, t, {lo_gate, hi_gate}, e);
        check(!(hi_gate && lo_gate), "R10", {lo_gate, hi_gate}, 0);
      end
    end
  end

  // Independent measurement of the gap between lower-off and upper-on (R5).
  int gap_cnt = -1;
  int gap_seen = -1;
  logic prev_lo = 0;
  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (prev_lo && !lo_gate) gap_cnt = 0;
      else if (gap_cnt >= 0 && !hi_gate) gap_cnt++;
      if (gap_cnt >= 0 && hi_gate) begin
        gap_seen = gap_cnt + 1;
        gap_cnt = -1;
      end
      prev_lo = lo_gate;
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, with commands asserted during reset
    hi_cmd = 1; lo_cmd = 0;
    repeat (DT + 3) @(negedge clk);
    check(hi_gate == 0 && lo_gate == 0, "R1", {lo_gate, hi_gate}, 0);
    hi_cmd = 0;
    @(negedge clk);
    rst_n = 1;

    // R3 / R4: upper side on then off
    run(1, 0, 0, 0, DT + 6, "R3");
    run(0, 0, 0, 0, 3, "R4");
    // R6: lower side, same timing
    run(0, 1, 0, 0, DT + 6, "R6");
    run(0, 0, 0, 0, 3, "R6");

    // R5: direct swap lower -> upper with zero external gap
    run(0, 1, 0, 0, DT + 4, "R5");
    gap_seen = -1;
    run(1, 0, 0, 0, DT + 4, "R5");
    @(negedge clk);
    check(gap_seen == DT, "R5", gap_seen, DT);
    run(0, 1, 0, 0, DT + 4, "R5");

    // R2: both high while one side on
    run(1, 1, 0, 0, 4, "R2");
    run(1, 0, 0, 0, DT + 3, "R2");
    run(1, 1, 0, 0, 3, "R2");

    // R7: short pulses after the other side was on
    run(0, 1, 0, 0, DT + 3, "R7");
    run(1, 0, 0, 0, DT, "R7");
    run(0, 0, 0, 0, 3, "R7");
    run(0, 1, 0, 0, DT - 1, "R7");
    run(0, 0, 0, 0, 3, "R7");

    // R8: force mid-count and while on, then a full wait again
    run(1, 0, 0, 0, 3, "R8");
    run(1, 0, 1, 0, 2, "R8");
    run(1, 0, 0, 0, DT + 3, "R8");
    run(1, 0, 1, 0, 1, "R8");
    run(1, 0, 0, 0, DT + 3, "R8");
    run(0, 0, 0, 0, 2, "R8");

    // R9: hold mid-count, and hold while on with inputs swapped
    run(0, 1, 0, 0, 3, "R9");
    run(0, 1, 0, 1, 4, "R9");
    run(0, 1, 0, 0, DT + 2, "R9");
    run(1, 0, 0, 1, 5, "R9");
    run(1, 1, 0, 1, 2, "R9");
    run(1, 0, 0, 0, DT + 3, "R9");

    // R11: force with hold together
    run(1, 0, 1, 1, 2, "R11");
    run(1, 0, 0, 1, 2, "R11");
    run(1, 0, 0, 0, DT + 3, "R11");
    run(0, 0, 0, 0, 3, "R11");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule